// File: doc/BRIEF.md
# Translation Lookaside Buffer with Use and Modify Tracking

This block is a small fully associative translation cache for 4 KB pages. A requester presents a virtual address with a valid strobe and a write flag. In the same cycle the block either returns the physical address with a hit flag, or raises a miss. The miss comes early enough that the requester can cancel its destination write and hand the fault to software. The low twelve address bits are the page offset and pass through unchanged. The page number is compared against every stored entry at once.

Software services a miss by writing a complete entry through the refill port. An entry holds the virtual page, the physical page, the initial use bit and the initial modify bit. The block then maintains the status bits itself: any hit marks its entry as recently used, and a write hit also marks it as modified. A use-clear strobe ages all entries at once. A flush strobe drops every entry.

A refill picks its slot by a fixed rule that approximates least-recently-used replacement. In the same cycle it reports the page number and modify bit of any valid entry it displaces, so that software can copy that status back to its page table.

Top module: `pte_tlb`

## Requirements
- R1: When `req_vld` is high and a valid entry holds the virtual page `req_va[31:12]`, `rsp_hit` is 1 in that same cycle and `rsp_pa` equals that entry's physical page concatenated with `req_va[11:0]`.
- R2: When `req_vld` is high and no valid entry matches, `rsp_miss` is 1, `rsp_hit` is 0 and `rsp_pa` is 0 in that same cycle. When `req_vld` is low, both `rsp_hit` and `rsp_miss` are 0 and `rsp_pa` is 0.
- R3: A hit sets the use bit of the matching entry from the next cycle on. The effect shows in which slot later refills choose.
- R4: A hit with `req_wr`=1 sets the modify bit of the matching entry. A hit with `req_wr`=0 leaves the modify bit unchanged. The modify bit is seen in `evict_dirty` when that entry is later displaced.
- R5: `ref_clear` zeroes every use bit at the clock edge. If a hit happens in the same cycle, its entry still ends with the use bit set.
- R6: A refill writes the lowest-indexed invalid slot. If all slots are valid, it writes the lowest-indexed slot whose use bit is 0. If every use bit is 1, it writes slot 0.
- R7: In a cycle with `fill_vld`=1 whose chosen slot holds a valid entry, `evict_vld` is 1 and `evict_vpn` and `evict_dirty` show that entry's virtual page and modify bit. Otherwise all three are 0.
- R8: `flush` invalidates every entry at the clock edge. A lookup in the flush cycle still sees the old contents. A refill in the flush cycle survives the flush.
- R9: A refill loads `fill_vpn`, `fill_ppn`, `fill_ref` and `fill_dirty` into a valid entry, and a retried lookup of that page hits from the next cycle on.
- R10: After reset every entry is invalid, so every lookup misses.
- R11: Every lookup, slot choice and eviction report in a cycle uses the contents held at the start of that cycle. A lookup of a page that is being refilled in the same cycle misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Lookup request strobe |
| req_wr | input | 1 | Lookup is a store access |
| req_va | input | 32 | Virtual address to translate |
| rsp_hit | output | 1 | Translation found this cycle |
| rsp_miss | output | 1 | Miss exception this cycle |
| rsp_pa | output | 32 | Translated physical address, 0 unless hit |
| fill_vld | input | 1 | Refill write strobe |
| fill_vpn | input | 20 | Virtual page of the new entry |
| fill_ppn | input | 20 | Physical page of the new entry |
| fill_ref | input | 1 | Initial use bit of the new entry |
| fill_dirty | input | 1 | Initial modify bit of the new entry |
| evict_vld | output | 1 | Refill displaces a valid entry |
| evict_vpn | output | 20 | Virtual page of the displaced entry |
| evict_dirty | output | 1 | Modify bit of the displaced entry |
| ref_clear | input | 1 | Zero all use bits |
| flush | input | 1 | Invalidate all entries |

## Verification
Two collisions matter most. The first is an aging strobe arriving in the same cycle as a hit, where the hit's use mark must survive the clear. The second is a flush landing together with a lookup and a refill, where the lookup must still see the old contents and the new entry must outlive the invalidation. Directed sequences force both collisions with known slot contents. The outcome is judged through the next refills, whose choice of slot and eviction report expose the use bits. A random phase mixes lookups, refills, aging and flushes at fixed rates and compares every output with a behavioural model on every clock.

// File: rtl/pte_tlb_pkg.sv
package pte_tlb_pkg;
   localparam int unsigned PAGE_OFS_W = 12;

   typedef struct packed {
      logic valid;
      logic refd;
      logic dirty;
   } ent_flags_t;
endpackage

// File: rtl/pte_tlb_match.sv
// Parallel page-number compare across all slots, with one-hot select of the physical page.
module pte_tlb_match #(
   parameter  int ENTRIES = 16,
   parameter  int VPN_W   = 20,
   parameter  int PPN_W   = 20,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]            valid,
   input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
   input  logic [ENTRIES-1:0][PPN_W-1:0] ppns,
   input  logic [VPN_W-1:0]              key,
   output logic                          any_hit,
   output logic [IDX_W-1:0]              hit_idx,
   output logic [PPN_W-1:0]              hit_ppn
);
   logic [ENTRIES-1:0] hv;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hv[g] = valid[g] && (tags[g] == key);
   end

   always_comb begin
      any_hit = |hv;
      hit_idx = '0;
      hit_ppn = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hv[i]) begin
            hit_idx = hit_idx | IDX_W'(i);
            hit_ppn = hit_ppn | ppns[i];
         end
      end
   end
endmodule

// File: rtl/pte_tlb_victim.sv
// Slot choice: lowest invalid, else lowest not-recently-used, else slot 0.
module pte_tlb_victim #(
   parameter  int ENTRIES = 16,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] valid,
   input  logic [ENTRIES-1:0] refd,
   output logic [IDX_W-1:0]   vic_idx
);
   logic             inv_found, cold_found;
   logic [IDX_W-1:0] inv_idx, cold_idx;

   always_comb begin
      inv_found  = 1'b0;
      cold_found = 1'b0;
      inv_idx    = '0;
      cold_idx   = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            inv_found = 1'b1;
            inv_idx   = IDX_W'(i);
         end
         if (!refd[i]) begin
            cold_found = 1'b1;
            cold_idx   = IDX_W'(i);
         end
      end
      if (inv_found)       vic_idx = inv_idx;
      else if (cold_found) vic_idx = cold_idx;
      else                 vic_idx = '0;
   end
endmodule

// File: rtl/pte_tlb_store.sv
// Entry storage and status-bit update ordering: flush/age, then hit marking, then refill.
module pte_tlb_store
   import pte_tlb_pkg::*;
#(
   parameter  int ENTRIES = 16,
   parameter  int VPN_W   = 20,
   parameter  int PPN_W   = 20,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          ref_clr,
   input  logic                          hit_en,
   input  logic                          hit_wr,
   input  logic [IDX_W-1:0]              hit_idx,
   input  logic                          fill_en,
   input  logic [IDX_W-1:0]              fill_idx,
   input  logic [VPN_W-1:0]              fill_vpn,
   input  logic [PPN_W-1:0]              fill_ppn,
   input  logic                          fill_ref,
   input  logic                          fill_dirty,
   output logic [ENTRIES-1:0]            valid_o,
   output logic [ENTRIES-1:0]            refd_o,
   output logic [ENTRIES-1:0]            dirty_o,
   output logic [ENTRIES-1:0][VPN_W-1:0] tags_o,
   output logic [ENTRIES-1:0][PPN_W-1:0] ppns_o
);
   ent_flags_t [ENTRIES-1:0] flg_q, flg_d;

   always_comb begin
      flg_d = flg_q;
      for (int i = 0; i < ENTRIES; i++) begin
         if (flush)   flg_d[i].valid = 1'b0;
         if (ref_clr) flg_d[i].refd  = 1'b0;
      end
      if (hit_en) begin
         flg_d[hit_idx].refd = 1'b1;
         if (hit_wr) flg_d[hit_idx].dirty = 1'b1;
      end
      if (fill_en) begin
         flg_d[fill_idx].valid = 1'b1;
         flg_d[fill_idx].refd  = fill_ref;
         flg_d[fill_idx].dirty = fill_dirty;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q <= '0;
      else        flg_q <= flg_d;
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic [VPN_W-1:0] tag_q;
      logic [PPN_W-1:0] ppn_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_q <= '0;
            ppn_q <= '0;
         end else if (fill_en && (fill_idx == IDX_W'(g))) begin
            tag_q <= fill_vpn;
            ppn_q <= fill_ppn;
         end
      end

      assign tags_o[g]  = tag_q;
      assign ppns_o[g]  = ppn_q;
      assign valid_o[g] = flg_q[g].valid;
      assign refd_o[g]  = flg_q[g].refd;
      assign dirty_o[g] = flg_q[g].dirty;
   end
endmodule

// File: rtl/pte_tlb.sv
module pte_tlb #(
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int OFS_W   = pte_tlb_pkg::PAGE_OFS_W,
   parameter int ENTRIES = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_vld,
   input  logic                    req_wr,
   input  logic [VA_W-1:0]         req_va,
   output logic                    rsp_hit,
   output logic                    rsp_miss,
   output logic [PA_W-1:0]         rsp_pa,
   input  logic                    fill_vld,
   input  logic [VA_W-OFS_W-1:0]   fill_vpn,
   input  logic [PA_W-OFS_W-1:0]   fill_ppn,
   input  logic                    fill_ref,
   input  logic                    fill_dirty,
   output logic                    evict_vld,
   output logic [VA_W-OFS_W-1:0]   evict_vpn,
   output logic                    evict_dirty,
   input  logic                    ref_clear,
   input  logic                    flush
);
   localparam int VPN_W = VA_W - OFS_W;
   localparam int PPN_W = PA_W - OFS_W;
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("pte_tlb: ENTRIES must be at least 2");
   end
   if (OFS_W < 1 || OFS_W >= VA_W || OFS_W >= PA_W) begin : g_bad_offset
      $error("pte_tlb: OFS_W must lie between 1 and the address widths");
   end

   logic [ENTRIES-1:0]            valid_v, refd_v, dirty_v;
   logic [ENTRIES-1:0][VPN_W-1:0] tags;
   logic [ENTRIES-1:0][PPN_W-1:0] ppns;
   logic                          any_hit;
   logic [IDX_W-1:0]              hit_idx, vic_idx;
   logic [PPN_W-1:0]              hit_ppn;

   pte_tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_match (
      .valid   (valid_v),
      .tags    (tags),
      .ppns    (ppns),
      .key     (req_va[VA_W-1:OFS_W]),
      .any_hit (any_hit),
      .hit_idx (hit_idx),
      .hit_ppn (hit_ppn)
   );

   pte_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
      .valid   (valid_v),
      .refd    (refd_v),
      .vic_idx (vic_idx)
   );

   pte_tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .ref_clr    (ref_clear),
      .hit_en     (rsp_hit),
      .hit_wr     (req_wr),
      .hit_idx    (hit_idx),
      .fill_en    (fill_vld),
      .fill_idx   (vic_idx),
      .fill_vpn   (fill_vpn),
      .fill_ppn   (fill_ppn),
      .fill_ref   (fill_ref),
      .fill_dirty (fill_dirty),
      .valid_o    (valid_v),
      .refd_o     (refd_v),
      .dirty_o    (dirty_v),
      .tags_o     (tags),
      .ppns_o     (ppns)
   );

   assign rsp_hit     = req_vld & any_hit;
   assign rsp_miss    = req_vld & ~any_hit;
   assign rsp_pa      = rsp_hit ? {hit_ppn, req_va[OFS_W-1:0]} : '0;
   assign evict_vld   = fill_vld & valid_v[vic_idx];
   assign evict_vpn   = evict_vld ? tags[vic_idx] : '0;
   assign evict_dirty = evict_vld & dirty_v[vic_idx];
endmodule

// File: rtl/pte_tlb_chk.sv
module pte_tlb_chk #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 32,
   parameter int OFS_W = 12
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_vld,
   input logic [VA_W-1:0]       req_va,
   input logic                  rsp_hit,
   input logic                  rsp_miss,
   input logic [PA_W-1:0]       rsp_pa,
   input logic                  fill_vld,
   input logic [VA_W-OFS_W-1:0] fill_vpn,
   input logic                  evict_vld,
   input logic                  flush
);
   p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |-> (rsp_hit != rsp_miss));

   p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |-> (!rsp_hit && !rsp_miss));

   p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_pa[OFS_W-1:0] == req_va[OFS_W-1:0]));

   p_evict_with_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evict_vld |-> fill_vld);

   p_retry_hits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_vld |=> ((req_vld && (req_va[VA_W-1:OFS_W] == $past(fill_vpn))) |-> rsp_hit));

   p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !fill_vld) |=> !rsp_hit);
endmodule

bind pte_tlb pte_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_vld   (req_vld),
   .req_va    (req_va),
   .rsp_hit   (rsp_hit),
   .rsp_miss  (rsp_miss),
   .rsp_pa    (rsp_pa),
   .fill_vld  (fill_vld),
   .fill_vpn  (fill_vpn),
   .evict_vld (evict_vld),
   .flush     (flush)
);

// File: tb/sim_pte_tlb.sv
`timescale 1ns/100ps
module sim_pte_tlb;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0, req_wr = 1'b0;
   logic [31:0] req_va = '0;
   logic        rsp_hit, rsp_miss;
   logic [31:0] rsp_pa;
   logic        fill_vld = 1'b0, fill_ref = 1'b0, fill_dirty = 1'b0;
   logic [19:0] fill_vpn = '0, fill_ppn = '0;
   logic        evict_vld, evict_dirty;
   logic [19:0] evict_vpn;
   logic        ref_clear = 1'b0, flush = 1'b0;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // behavioural model state
   bit mv[N];
   bit mr[N];
   bit md[N];
   int mvpn[N];
   int mppn[N];

   always #2.5 clk = ~clk;

   pte_tlb u0 (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr), .req_va(req_va),
      .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa),
      .fill_vld(fill_vld), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_ref(fill_ref), .fill_dirty(fill_dirty),
      .evict_vld(evict_vld), .evict_vpn(evict_vpn), .evict_dirty(evict_dirty),
      .ref_clear(ref_clear), .flush(flush)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic bit present(input int vpn);
      for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == vpn) return 1'b1;
      return 1'b0;
   endfunction

   task automatic quiet();
      req_vld = 0; req_wr = 0; req_va = '0;
      fill_vld = 0; fill_vpn = '0; fill_ppn = '0; fill_ref = 0; fill_dirty = 0;
      ref_clear = 0; flush = 0;
   endtask

   task automatic look(input bit wr, input int vpn);
      req_vld = 1; req_wr = wr; req_va = {vpn[19:0], 12'h5a3 ^ 12'(vpn)};
   endtask

   task automatic load(input int vpn, input int ppn, input bit r, input bit d);
      fill_vld = 1; fill_vpn = vpn[19:0]; fill_ppn = ppn[19:0]; fill_ref = r; fill_dirty = d;
   endtask

   // explicit eviction expectation, sampled before the model comparison
   task automatic expect_ev(input string tag, input bit v, input int vpn, input bit d);
      #0.5;
      chk(tag, "evict_vld", 32'(evict_vld), 32'(v));
      chk(tag, "evict_vpn", 32'(evict_vpn), 32'(vpn));
      chk(tag, "evict_dirty", 32'(evict_dirty), 32'(d));
   endtask

   // compare all outputs with the model, then advance one clock and update the model
   task automatic step(input string tag);
      int hi, vic;
      bit e_hit, e_miss, e_ev;
      logic [31:0] e_pa;
      #1;
      hi = -1;
      for (int i = 0; i < N; i++) if (hi < 0 && mv[i] && mvpn[i] == int'(req_va[31:12])) hi = i;
      vic = -1;
      for (int i = 0; i < N; i++) if (vic < 0 && !mv[i]) vic = i;
      for (int i = 0; i < N; i++) if (vic < 0 && !mr[i]) vic = i;
      if (vic < 0) vic = 0;
      e_hit  = req_vld && hi >= 0;
      e_miss = req_vld && hi < 0;
      e_pa   = e_hit ? {mppn[hi][19:0], req_va[11:0]} : 32'h0;
      e_ev   = fill_vld && mv[vic];
      chk(tag, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
      chk(tag, "rsp_miss", 32'(rsp_miss), 32'(e_miss));
      chk(tag, "rsp_pa", rsp_pa, e_pa);
      chk(tag, "evict_vld", 32'(evict_vld), 32'(e_ev));
      chk(tag, "evict_vpn", 32'(evict_vpn), e_ev ? mvpn[vic] : 0);
      chk(tag, "evict_dirty", 32'(evict_dirty), 32'(e_ev && md[vic]));
      @(posedge clk);
      if (flush) for (int i = 0; i < N; i++) mv[i] = 0;
      if (ref_clear) for (int i = 0; i < N; i++) mr[i] = 0;
      if (e_hit) begin
         mr[hi] = 1;
         if (req_wr) md[hi] = 1;
      end
      if (fill_vld) begin
         mv[vic] = 1; mr[vic] = fill_ref; md[vic] = fill_dirty;
         mvpn[vic] = int'(fill_vpn); mppn[vic] = int'(fill_ppn);
      end
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin mv[i] = 0; mr[i] = 0; md[i] = 0; mvpn[i] = 0; mppn[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R10: empty after reset
      quiet(); look(0, 'h100); step("R10");
      // R2: idle request gives no outcome
      quiet(); step("R2");

      // R11: lookup of the page being refilled in the same cycle misses
      quiet(); load('h100, 'h800, 0, 0); look(0, 'h100); expect_ev("R7", 0, 0, 0); step("R11");
      // R6: fill invalid slots in order, no eviction
      for (int i = 1; i < N; i++) begin
         quiet(); load('h100 + i, 'h800 + i, 0, 0); expect_ev("R6", 0, 0, 0); step("R6");
      end
      // R1 and R9: retried lookups hit
      quiet(); look(0, 'h100); step("R1");
      quiet(); look(1, 'h102); step("R4");
      quiet(); look(0, 'h10f); step("R9");

      // R3: slots 0,2,15 now recently used; lowest cold slot is 1
      quiet(); load('h200, 'h900, 1, 0); expect_ev("R3", 1, 'h101, 0); step("R3");
      quiet(); load('h201, 'h901, 1, 0); expect_ev("R6", 1, 'h103, 0); step("R6");
      for (int i = 4; i < N; i++) begin quiet(); look(0, 'h100 + i); step("R3"); end
      // R6: every use bit set, slot 0 replaced
      quiet(); load('h202, 'h902, 1, 0); expect_ev("R6", 1, 'h100, 0); step("R6");

      // R5: aging together with a hit on slot 3
      quiet(); ref_clear = 1; look(0, 'h201); step("R5");
      quiet(); load('h300, 'ha00, 1, 0); expect_ev("R5", 1, 'h202, 0); step("R5");
      quiet(); load('h301, 'ha01, 1, 0); expect_ev("R5", 1, 'h200, 0); step("R5");
      // R4: write-hit slot 2 reports its modify bit
      quiet(); load('h302, 'ha02, 1, 0); expect_ev("R4", 1, 'h102, 1); step("R4");
      // R5: slot 3 kept its use mark, so slot 4 goes next
      quiet(); load('h303, 'ha03, 1, 0); expect_ev("R5", 1, 'h104, 0); step("R5");

      // R8: flush with lookup and refill in the same cycle
      quiet(); flush = 1; look(0, 'h300); load('h400, 'hb00, 0, 1); step("R8");
      quiet(); look(0, 'h300); step("R8");
      quiet(); look(1, 'h400); step("R8");
      quiet(); flush = 1; step("R8");
      quiet(); look(0, 'h400); step("R8");

      // R11: mixed traffic against the model
      for (int n = 0; n < 4000; n++) begin
         int k, v;
         quiet();
         k = int'($urandom % N);
         v = ($urandom % 2 == 0 && mv[k]) ? mvpn[k] : 'h500 + int'($urandom % 40);
         if ($urandom % 4 != 0) look(bit'($urandom % 2), v);
         if ($urandom % 6 == 0) begin
            for (int t = 0; t < 8; t++) begin
               int c;
               c = 'h500 + int'($urandom % 40);
               if (!fill_vld && !present(c))
                  load(c, int'($urandom % 'h100000), bit'($urandom % 2), bit'($urandom % 2));
            end
         end
         if ($urandom % 20 == 0) ref_clear = 1;
         if ($urandom % 60 == 0) flush = 1;
         step("R11");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule